// File: doc/BRIEF.md
# Dual-Granularity SPI Clock Divider

This block turns a fast interface clock into the timing for an SPI serial clock. It does not produce a clock net. It produces a registered phase level, plus a rising-edge strobe and a falling-edge strobe that are each one interface cycle wide. A transfer engine uses the strobes to launch and capture data. Clock polarity and data shifting belong to that engine.

Two division modes are available, chosen by a mode bit:

- **Coarse mode** divides by a power of two named by a 4-bit code.
- **Fine mode** divides by any integer from 1 to 4096. The 12-bit ratio field is the 8-bit extension field followed by the 4-bit low field.

The ratio in use is captured only while the divider is idle, or at the end of each high phase. A new setting therefore never cuts a serial-clock period short.

Top module: `spi_sclk_divider`

## Requirements
- R1: With `fine_mode`=0, the division ratio N is 2 raised to `div_lo`. A steady run has `rise_stb` pulses N cycles apart, and `sclk_phase` is high for N/2 of those cycles.
- R2: With `fine_mode`=1, N is the 12-bit value {`div_ext`,`div_lo`} plus one. `div_ext` forms bits 11..4 and `div_lo` forms bits 3..0. For example, ext=1 and lo=2 gives N=19.
- R3: The extreme settings are honoured. Fine mode with all ones gives a 4096-cycle period. Coarse code 15 gives a 32768-cycle period.
- R4: For an odd N, the high phase lasts floor(N/2) cycles and the low phase lasts ceil(N/2) cycles.
- R5: A ratio of 1 or 2 toggles `sclk_phase` on every cycle. In that case exactly one strobe fires on each cycle, and the rising and falling strobes alternate.
- R6: `rise_stb` is high exactly in the first cycle in which `sclk_phase` reads 1. `fall_stb` is high exactly in the first cycle in which it reads 0 after being high. The two strobes are never high together.
- R7: While `en` is low, from the next cycle on, `sclk_phase`, `rise_stb` and `fall_stb` are 0 and the count is cleared. After `en` goes high, the first `rise_stb` appears ceil(N/2) cycles later.
- R8: A change of the ratio inputs while `en` is high does not shorten or stretch the phase in progress. The new ratio applies from the low phase that follows the next falling strobe.
- R9: During reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run the divider. When low, the divider is held idle |
| fine_mode | input | 1 | 0 selects power-of-two steps; 1 selects one-cycle steps |
| div_lo | input | 4 | Exponent in coarse mode; low ratio bits in fine mode |
| div_ext | input | 8 | High ratio bits in fine mode |
| sclk_phase | output | 1 | Divided clock level |
| rise_stb | output | 1 | One-cycle pulse on the phase going high |
| fall_stb | output | 1 | One-cycle pulse on the phase going low |

## Verification
The bench targets the corner cases where a divider usually goes wrong:

- **Ratio 1.** A design that subtracts one without a floor would stall or never rise.
- **Odd fine ratios.** A wrong rounding choice swaps the high and low lengths.
- **Field ordering.** A swapped concatenation of the two ratio fields gives a period far from 19.
- **The largest coarse and fine settings.** A counter that is too narrow wraps early.
- **Ratio change in the middle of a high phase.** A design that loads the ratio at once emits a runt high phase, so the falling strobe arrives early.
- **Disable and the first-rise latency.** These expose a counter that is not cleared.

// File: rtl/spi_div_pkg.sv
package spi_div_pkg;
   function automatic int max_i(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // width of the full ratio value for a given field layout
   function automatic int ratio_width(input int lo_w, input int ext_w);
      return max_i((1 << lo_w), lo_w + ext_w + 1);
   endfunction
endpackage

// File: rtl/spi_div_ratio_decode.sv
module spi_div_ratio_decode #(
   parameter int LO_W    = 4,
   parameter int EXT_W   = 8,
   parameter bit FINE_EN = 1'b1,
   parameter int RAT_W   = 16,
   parameter int TC_W    = 15
) (
   input  logic             fine_mode,
   input  logic [LO_W-1:0]  div_lo,
   input  logic [EXT_W-1:0] div_ext,
   output logic [TC_W-1:0]  low_tc,
   output logic [TC_W-1:0]  high_tc
);
   logic [RAT_W-1:0] n_coarse;
   logic [RAT_W-1:0] n_fine;
   logic [RAT_W-1:0] n_sel;
   logic [RAT_W-1:0] half;
   logic [RAT_W-1:0] low_len;
   logic [RAT_W-1:0] high_len;

   assign n_coarse = RAT_W'(1) << div_lo;

   generate
      if (FINE_EN) begin : g_fine
         assign n_fine = RAT_W'({div_ext, div_lo}) + RAT_W'(1);
      end else begin : g_coarse_only
         logic unused_fine;
         assign unused_fine = fine_mode ^ (^div_ext);
         assign n_fine      = n_coarse;
      end
   endgenerate

   always_comb begin
      n_sel    = fine_mode ? n_fine : n_coarse;
      half     = n_sel >> 1;
      low_len  = n_sel - half;
      high_len = (half == '0) ? RAT_W'(1) : half;
      low_tc   = TC_W'(low_len - RAT_W'(1));
      high_tc  = TC_W'(high_len - RAT_W'(1));
   end
endmodule

// File: rtl/spi_div_ratio_latch.sv
module spi_div_ratio_latch #(
   parameter int TC_W = 15
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [TC_W-1:0] low_tc_in,
   input  logic [TC_W-1:0] high_tc_in,
   output logic [TC_W-1:0] low_tc_q,
   output logic [TC_W-1:0] high_tc_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_tc_q  <= '0;
         high_tc_q <= '0;
      end else if (load) begin
         low_tc_q  <= low_tc_in;
         high_tc_q <= high_tc_in;
      end
   end
endmodule

// File: rtl/spi_div_half_timer.sv
module spi_div_half_timer #(
   parameter int TC_W = 15
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic [TC_W-1:0] low_tc,
   input  logic [TC_W-1:0] high_tc,
   output logic            phase_q,
   output logic            rise_q,
   output logic            fall_q,
   output logic [TC_W-1:0] cnt_q,
   output logic            high_end
);
   logic low_end;

   assign low_end  = en && !phase_q && (cnt_q == low_tc);
   assign high_end = en &&  phase_q && (cnt_q == high_tc);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= 1'b0;
         rise_q  <= 1'b0;
         fall_q  <= 1'b0;
         cnt_q   <= '0;
      end else if (!en) begin
         phase_q <= 1'b0;
         rise_q  <= 1'b0;
         fall_q  <= 1'b0;
         cnt_q   <= '0;
      end else begin
         rise_q <= low_end;
         fall_q <= high_end;
         if (low_end || high_end) begin
            phase_q <= !phase_q;
            cnt_q   <= '0;
         end else begin
            cnt_q   <= cnt_q + TC_W'(1);
         end
      end
   end
endmodule

// File: rtl/spi_sclk_divider.sv
module spi_sclk_divider
   import spi_div_pkg::*;
#(
   parameter int LO_W    = 4,
   parameter int EXT_W   = 8,
   parameter bit FINE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             fine_mode,
   input  logic [LO_W-1:0]  div_lo,
   input  logic [EXT_W-1:0] div_ext,
   output logic             sclk_phase,
   output logic             rise_stb,
   output logic             fall_stb
);
   localparam int RAT_W = ratio_width(LO_W, EXT_W);
   localparam int TC_W  = RAT_W - 1;

   generate
      if (LO_W < 2 || LO_W > 4) begin : g_bad_lo
         $error("spi_sclk_divider: LO_W must be 2..4");
      end
      if (EXT_W < 1 || EXT_W > 12) begin : g_bad_ext
         $error("spi_sclk_divider: EXT_W must be 1..12");
      end
   endgenerate

   logic [TC_W-1:0] dec_low_tc;
   logic [TC_W-1:0] dec_high_tc;
   logic [TC_W-1:0] act_low_tc;
   logic [TC_W-1:0] act_high_tc;
   logic [TC_W-1:0] cnt_q;
   logic            high_end;
   logic            ratio_load;

   assign ratio_load = !en || high_end;

   spi_div_ratio_decode #(
      .LO_W(LO_W), .EXT_W(EXT_W), .FINE_EN(FINE_EN), .RAT_W(RAT_W), .TC_W(TC_W)
   ) u_decode (
      .fine_mode (fine_mode),
      .div_lo    (div_lo),
      .div_ext   (div_ext),
      .low_tc    (dec_low_tc),
      .high_tc   (dec_high_tc)
   );

   spi_div_ratio_latch #(.TC_W(TC_W)) u_latch (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (ratio_load),
      .low_tc_in  (dec_low_tc),
      .high_tc_in (dec_high_tc),
      .low_tc_q   (act_low_tc),
      .high_tc_q  (act_high_tc)
   );

   spi_div_half_timer #(.TC_W(TC_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .low_tc   (act_low_tc),
      .high_tc  (act_high_tc),
      .phase_q  (sclk_phase),
      .rise_q   (rise_stb),
      .fall_q   (fall_stb),
      .cnt_q    (cnt_q),
      .high_end (high_end)
   );
endmodule

// File: rtl/spi_sclk_divider_chk.sv
module spi_sclk_divider_chk #(
   parameter int TC_W = 15
) (
   input logic            clk,
   input logic            rst_n,
   input logic            en,
   input logic            sclk_phase,
   input logic            rise_stb,
   input logic            fall_stb,
   input logic [TC_W-1:0] cnt_q,
   input logic [TC_W-1:0] act_low_tc,
   input logic [TC_W-1:0] act_high_tc
);
   AST_RISE_MARKS_UP: assert property (@(posedge clk) disable iff (!rst_n)
      rise_stb |-> (sclk_phase && !$past(sclk_phase))); // R6
   AST_FALL_MARKS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      fall_stb |-> (!sclk_phase && $past(sclk_phase))); // R6
   AST_PHASE_UP_STROBED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk_phase) |-> rise_stb); // R6
   AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise_stb && fall_stb)); // R6
   AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!sclk_phase && !rise_stb && !fall_stb && cnt_q == '0)); // R7
   AST_RATIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en) && !fall_stb) |-> ($stable(act_low_tc) && $stable(act_high_tc))); // R8
   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= (sclk_phase ? act_high_tc : act_low_tc)); // R4
endmodule

bind spi_sclk_divider spi_sclk_divider_chk #(.TC_W(TC_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .en          (en),
   .sclk_phase  (sclk_phase),
   .rise_stb    (rise_stb),
   .fall_stb    (fall_stb),
   .cnt_q       (cnt_q),
   .act_low_tc  (act_low_tc),
   .act_high_tc (act_high_tc)
);

// File: tb/spi_sclk_divider_tb.sv
module spi_sclk_divider_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 200000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic       fine_mode = 1'b0;
   logic [3:0] div_lo = '0;
   logic [7:0] div_ext = '0;
   logic       sclk_phase, rise_stb, fall_stb;

   int  n_checks = 0;
   int  n_fails  = 0;
   bit  done     = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_sclk_divider u_dut (
      .clk(clk), .rst_n(rst_n), .en(en), .fine_mode(fine_mode),
      .div_lo(div_lo), .div_ext(div_ext),
      .sclk_phase(sclk_phase), .rise_stb(rise_stb), .fall_stb(fall_stb)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int m_cnt = 0, m_low = 1, m_high = 1;
   bit m_phase = 0, m_rise = 0, m_fall = 0;

   function automatic void lengths(output int lo_len, output int hi_len);
      int n;
      if (fine_mode) n = (int'(div_ext) * 16) + int'(div_lo) + 1;
      else           n = 1 << div_lo;
      hi_len = n / 2;
      lo_len = n - hi_len;
      if (hi_len == 0) hi_len = 1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_phase = 0; m_rise = 0; m_fall = 0; m_low = 1; m_high = 1;
      end else if (!en) begin
         m_cnt = 0; m_phase = 0; m_rise = 0; m_fall = 0;
         lengths(m_low, m_high);
      end else begin
         m_rise = 0; m_fall = 0;
         if (!m_phase) begin
            if (m_cnt == m_low - 1) begin m_phase = 1; m_cnt = 0; m_rise = 1; end
            else m_cnt++;
         end else begin
            if (m_cnt == m_high - 1) begin
               m_phase = 0; m_cnt = 0; m_fall = 1;
               lengths(m_low, m_high);
            end else m_cnt++;
         end
      end
   end

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(sclk_phase == m_phase, "R6 phase vs model", sclk_phase, m_phase);
         check(rise_stb == m_rise,    "R6 rise vs model",  rise_stb,   m_rise);
         check(fall_stb == m_fall,    "R6 fall vs model",  fall_stb,   m_fall);
      end
   end

   // ---------------- directed helpers ----------------
   task automatic setup(input bit fm, input int lo, input int ext);
      @(negedge clk);
      en = 0;
      fine_mode = fm; div_lo = 4'(lo); div_ext = 8'(ext);
      @(negedge clk);
      en = 1;
   endtask

   task automatic measure(input int exp_per, input int exp_hi, input string req);
      int w = 0, per = 0, hi = 0;
      @(negedge clk);
      while (!rise_stb && w < 70000) begin @(negedge clk); w++; end
      do begin
         if (sclk_phase) hi++;
         per++;
         @(negedge clk);
      end while (!rise_stb && per < 70000);
      check(per == exp_per, {req, " period"}, per, exp_per);
      check(hi == exp_hi,   {req, " high cycles"}, hi, exp_hi);
   endtask

   initial begin
      #(CLK_PERIOD * WD_CYCLES);
      if (!done) begin
         n_checks++; n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check({sclk_phase, rise_stb, fall_stb} == 3'b000, "R9 reset outputs",
            {sclk_phase, rise_stb, fall_stb}, 0);
      rst_n = 1;

      // R7 first-rise latency, N=8 -> rise after 4 enabled edges
      setup(0, 3, 0);
      for (int i = 1; i <= 4; i++) begin
         @(negedge clk);
         check(rise_stb == (i == 4), "R7 first rise latency", rise_stb, i == 4);
      end
      measure(8, 4, "R1 coarse N=8");

      setup(0, 0, 0);
      measure(2, 1, "R5 ratio 1");
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         check((rise_stb ^ fall_stb) == 1'b1, "R5 one strobe per cycle", rise_stb ^ fall_stb, 1);
      end
      setup(1, 1, 0);
      measure(2, 1, "R5 ratio 2");

      setup(0, 5, 0);
      measure(32, 16, "R1 coarse N=32");

      setup(1, 4, 0);
      measure(5, 2, "R4 odd N=5");
      setup(1, 2, 1);
      measure(19, 9, "R2 concat N=19");
      setup(1, 15, 255);
      measure(4096, 2048, "R3 fine max");
      setup(0, 15, 0);
      measure(32768, 16384, "R3 coarse max");

      // R8 change ratio during a high phase
      setup(1, 9, 0);
      begin
         int hi = 0;
         @(negedge clk);
         while (!rise_stb) @(negedge clk);
         div_lo = 4'd3;
         while (!fall_stb) begin
            if (sclk_phase) hi++;
            @(negedge clk);
         end
         check(hi == 5, "R8 running high kept", hi, 5);
      end
      measure(4, 2, "R8 new ratio after boundary");

      // R7 disable mid-run
      setup(0, 4, 0);
      repeat (11) @(negedge clk);
      en = 0;
      @(negedge clk);
      check({sclk_phase, rise_stb, fall_stb} == 3'b000, "R7 idle after disable",
            {sclk_phase, rise_stb, fall_stb}, 0);
      repeat (3) @(negedge clk);
      check({sclk_phase, rise_stb, fall_stb} == 3'b000, "R7 idle held",
            {sclk_phase, rise_stb, fall_stb}, 0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule